// File: doc/BRIEF.md
# One-Bit Time-Stamp Packet Steering Cell

This cell sorts 34-bit hit packets onto two outputs by looking at a single bit of the 9-bit bunch-crossing stamp carried in each packet. A stage of a larger time-ordering network uses one such cell per routing bit. A parameter picks the bit, so the network can sort on either the high or the low stamp bits.

In the two-input form, every input-to-output pair has its own FIFO, which gives four in total. Each output drains whichever of its two candidate FIFOs holds more words. When the two fill levels are equal, a two-state machine alternates between them. The state `TIE_TAKE_A` gives the tie to the FIFO fed by input 0. The state `TIE_TAKE_B` gives it to the FIFO fed by input 1. Every transfer made on a tie moves the machine to the other state: `TIE_TAKE_A -> TIE_TAKE_B` and `TIE_TAKE_B -> TIE_TAKE_A`. In every other cycle the state holds.

The one-input form has no FIFOs. It places each packet in a one-deep register for the chosen output. In both forms a packet that finds no room is discarded, and a saturating drop counter records it.

Top module: `bit_steer_cell`

## Requirements
- R1: A packet is laid out as chip id in bits [33:30], superpixel address in [29:17], stamp in [16:8] and hit pattern in [7:0]. Stamp bit SEL_BIT (packet bit 8+SEL_BIT) is the route bit: 0 sends the packet to output 0 and 1 sends it to output 1.
- R2: Packets that travel from a given input to a given output leave in the order they arrived.
- R3: When the two candidate FIFOs of an output hold different word counts and ready is high, the output takes the word from the fuller one.
- R4: When the counts are equal and non-zero, the first tie after reset goes to the FIFO fed by input 0. Each transfer made on a tie then hands the next tie to the other FIFO.
- R5: An output's valid equals its ready AND (at least one candidate non-empty). Each valid cycle removes exactly one word, and the word removed is the one shown on the data port.
- R6: A packet whose target FIFO held DEPTH words at the start of the cycle is discarded. The FIFO contents do not change, and that FIFO's drop counter increments.
- R7: A drop counter that reaches all ones stays at all ones.
- R8: During and right after reset, both outputs are invalid, all FIFOs and output registers are empty, and all four drop counters read zero.
- R9: With DUAL_IN=0, input 0 writes a one-deep output register per output. The register accepts a packet when it is empty or is being drained in the same cycle. Otherwise the packet is dropped and counted on drop00 (output 0) or drop01 (output 1).
- R10: With DUAL_IN=0, input 1 has no effect on the outputs, and drop10/drop11 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Packet present on input 0 |
| in0_pkt | input | 34 | Packet on input 0 |
| in1_valid | input | 1 | Packet present on input 1 (ignored when DUAL_IN=0) |
| in1_pkt | input | 34 | Packet on input 1 |
| out0_ready | input | 1 | Downstream can take a word on output 0 |
| out0_valid | output | 1 | Word transferred on output 0 this cycle |
| out0_pkt | output | 34 | Word on output 0 |
| out1_ready | input | 1 | Downstream can take a word on output 1 |
| out1_valid | output | 1 | Word transferred on output 1 this cycle |
| out1_pkt | output | 34 | Word on output 1 |
| drop00 | output | DROP_W | Drops, input 0 toward output 0 |
| drop01 | output | DROP_W | Drops, input 0 toward output 1 |
| drop10 | output | DROP_W | Drops, input 1 toward output 0 |
| drop11 | output | DROP_W | Drops, input 1 toward output 1 |

## Verification
The first directed patterns send single packets with route bit 0 and then 1. These show whether the cell reads the correct stamp bit. A long burst from one input to one output, drained afterwards, exposes reordering. Uneven loads on the two FIFOs of one output exercise the fuller-first rule. Equal loads separate the alternating tie-break from a fixed preference. Holding ready low while packets keep arriving pushes the FIFOs and output registers into overflow and the counters into saturation. Traffic on input 1 alone shows that the one-input form ignores that input. A long seeded random run with mixed valid and ready rates is then compared cycle by cycle against a queue model in the bench.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int PKT_W     = 34;
    localparam int STAMP_LSB = 8;
    localparam int STAMP_W   = 9;

    typedef struct packed {
        logic [3:0]         chip;
        logic [12:0]        pixel;
        logic [STAMP_W-1:0] stamp;
        logic [7:0]         hits;
    } hit_pkt_t;

    typedef enum logic {
        TIE_TAKE_A = 1'b0,
        TIE_TAKE_B = 1'b1
    } tie_state_e;

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import steer_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DROP_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [PKT_W-1:0]  din,
    input  logic              pop,
    output logic [PKT_W-1:0]  dout,
    output logic [CNT_W-1:0]  count,
    output logic [DROP_W-1:0] drops
);

    logic [PKT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, accept;

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = push_req && !full;
    assign dout   = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drops  <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (pop)    rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(accept) - CNT_W'(pop);
            if (push_req && full && !(&drops)) drops <= drops + 1'b1;
        end
    end

    // R6: occupancy never passes the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R5: a word is removed only when one is stored
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    // R6: a discarded packet leaves the occupancy untouched
    a_r6_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop) |=> (count == $past(count)));
    // R7: a saturated counter stays saturated
    a_r7_drop_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (&drops) |=> (&drops));

endmodule

// File: rtl/out_arbiter.sv
module out_arbiter
    import steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             valid,
    output logic             pop_a,
    output logic             pop_b
);

    tie_state_e state, state_nx;
    logic a_more, b_more, any, tie, pick_a;

    always_comb begin
        a_more = cnt_a > cnt_b;
        b_more = cnt_b > cnt_a;
        any    = (cnt_a != '0) || (cnt_b != '0);
        tie    = any && !a_more && !b_more;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TIE_TAKE_A;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TIE_TAKE_A: if (ready && tie) state_nx = TIE_TAKE_B;
            TIE_TAKE_B: if (ready && tie) state_nx = TIE_TAKE_A;
        endcase
    end

    always_comb begin
        pick_a = 1'b0;
        unique case (state)
            TIE_TAKE_A: pick_a = a_more || tie;
            TIE_TAKE_B: pick_a = a_more;
        endcase
        pop_a = ready && any && pick_a;
        pop_b = ready && any && !pick_a;
        valid = pop_a || pop_b;
    end

    // R5: nothing moves without ready
    a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!pop_a && !pop_b));
    // R5: at most one word per cycle
    a_r5_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_a && pop_b));
    // R3: the fuller side wins
    a_r3_fuller_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cnt_a > cnt_b) |-> pop_a);
    a_r3_fuller_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cnt_b > cnt_a) |-> pop_b);

endmodule

// File: rtl/out_slot.sv
module out_slot
    import steer_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [PKT_W-1:0]  din,
    input  logic              pop,
    output logic [PKT_W-1:0]  dout,
    output logic              full,
    output logic [DROP_W-1:0] drops
);

    logic accept;
    assign accept = push_req && (!full || pop);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            dout  <= '0;
            drops <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                dout <= din;
            end else if (pop) begin
                full <= 1'b0;
            end
            if (push_req && !accept && !(&drops)) drops <= drops + 1'b1;
        end
    end

    // R9: an undrained, occupied register keeps its packet
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(dout)));
    // R7: saturation is sticky
    a_r7_slot_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (&drops) |=> (&drops));

endmodule

// File: rtl/bit_steer_cell.sv
module bit_steer_cell
    import steer_pkg::*;
#(
    parameter int SEL_BIT = 8,
    parameter int DEPTH   = 512,
    parameter int DROP_W  = 16,
    parameter int DUAL_IN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in0_valid,
    input  logic [PKT_W-1:0]  in0_pkt,
    input  logic              in1_valid,
    input  logic [PKT_W-1:0]  in1_pkt,
    input  logic              out0_ready,
    output logic              out0_valid,
    output logic [PKT_W-1:0]  out0_pkt,
    input  logic              out1_ready,
    output logic              out1_valid,
    output logic [PKT_W-1:0]  out1_pkt,
    output logic [DROP_W-1:0] drop00,
    output logic [DROP_W-1:0] drop01,
    output logic [DROP_W-1:0] drop10,
    output logic [DROP_W-1:0] drop11
);

    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int ROUTE_POS = STAMP_LSB + SEL_BIT;

    logic [PKT_W-1:0]  src_pkt [2];
    logic [1:0]        src_v;
    logic [1:0]        rdy;
    logic [1:0]        ov;
    logic [PKT_W-1:0]  opkt [2];
    logic [DROP_W-1:0] drop_v [4];

    assign src_v      = {in1_valid, in0_valid};
    assign src_pkt[0] = in0_pkt;
    assign src_pkt[1] = in1_pkt;
    assign rdy        = {out1_ready, out0_ready};
    assign out0_valid = ov[0];
    assign out1_valid = ov[1];
    assign out0_pkt   = opkt[0];
    assign out1_pkt   = opkt[1];
    assign drop00     = drop_v[0];
    assign drop01     = drop_v[1];
    assign drop10     = drop_v[2];
    assign drop11     = drop_v[3];

    generate
        if (DUAL_IN != 0) begin : g_dual
            logic [CNT_W-1:0] cnt  [4];
            logic [PKT_W-1:0] dout [4];
            logic [3:0]       pop;
            logic [3:0]       push;

            // FIFO index f: source input f/2, destination output f%2
            for (genvar f = 0; f < 4; f++) begin : g_fifo
                assign push[f] = src_v[f/2] && (src_pkt[f/2][ROUTE_POS] == 1'(f % 2));
                pkt_fifo #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_fifo (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .push_req (push[f]),
                    .din      (src_pkt[f/2]),
                    .pop      (pop[f]),
                    .dout     (dout[f]),
                    .count    (cnt[f]),
                    .drops    (drop_v[f])
                );
            end

            for (genvar o = 0; o < 2; o++) begin : g_out
                out_arbiter #(.CNT_W(CNT_W)) u_arb (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .ready (rdy[o]),
                    .cnt_a (cnt[o]),
                    .cnt_b (cnt[2+o]),
                    .valid (ov[o]),
                    .pop_a (pop[o]),
                    .pop_b (pop[2+o])
                );
                assign opkt[o] = pop[2+o] ? dout[2+o] : dout[o];
            end
        end else begin : g_single
            logic [1:0]       full;
            logic [1:0]       take;
            logic [PKT_W-1:0] held [2];

            for (genvar o = 0; o < 2; o++) begin : g_slot
                assign take[o] = rdy[o] && full[o];
                out_slot #(.DROP_W(DROP_W)) u_slot (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .push_req (src_v[0] && (src_pkt[0][ROUTE_POS] == 1'(o))),
                    .din      (src_pkt[0]),
                    .pop      (take[o]),
                    .dout     (held[o]),
                    .full     (full[o]),
                    .drops    (drop_v[o])
                );
                assign ov[o]   = take[o];
                assign opkt[o] = held[o];
            end
            assign drop_v[2] = '0;
            assign drop_v[3] = '0;
        end
    endgenerate

endmodule

// File: tb/sim_bit_steer_cell.sv
module sim_bit_steer_cell;
    import steer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PW    = PKT_W;
    localparam int DEPTH = 8;
    localparam int SEL0  = 2;
    localparam int SEL1  = 0;
    localparam int DW0   = 4;
    localparam int DW1   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v0 = 1'b0, v1 = 1'b0, r0 = 1'b0, r1 = 1'b0;
    logic [PW-1:0] p0 = '0, p1 = '0;

    logic          a_ov [2];
    logic [PW-1:0] a_op [2];
    logic [DW0-1:0] a_dr [4];
    logic          b_ov [2];
    logic [PW-1:0] b_op [2];
    logic [DW1-1:0] b_dr [4];

    int n_chk = 0, n_fail = 0;
    string tag = "R8";

    logic [PW-1:0] q [4][$];
    int drop0 [4];
    int tie [2];
    logic slot_v [2];
    logic [PW-1:0] slot_d [2];
    int drop1 [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_steer_cell #(.SEL_BIT(SEL0), .DEPTH(DEPTH), .DROP_W(DW0), .DUAL_IN(1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(v0), .in0_pkt(p0), .in1_valid(v1), .in1_pkt(p1),
        .out0_ready(r0), .out0_valid(a_ov[0]), .out0_pkt(a_op[0]),
        .out1_ready(r1), .out1_valid(a_ov[1]), .out1_pkt(a_op[1]),
        .drop00(a_dr[0]), .drop01(a_dr[1]), .drop10(a_dr[2]), .drop11(a_dr[3]));

    bit_steer_cell #(.SEL_BIT(SEL1), .DEPTH(DEPTH), .DROP_W(DW1), .DUAL_IN(0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(v0), .in0_pkt(p0), .in1_valid(v1), .in1_pkt(p1),
        .out0_ready(r0), .out0_valid(b_ov[0]), .out0_pkt(b_op[0]),
        .out1_ready(r1), .out1_valid(b_ov[1]), .out1_pkt(b_op[1]),
        .drop00(b_dr[0]), .drop01(b_dr[1]), .drop10(b_dr[2]), .drop11(b_dr[3]));

    function automatic logic rb(input logic [PW-1:0] p, input int sel);
        return p[STAMP_LSB + sel];
    endfunction

    function automatic logic [PW-1:0] mk(input logic [3:0] c, input logic [12:0] a,
                                         input logic [8:0] s, input logic [7:0] h);
        hit_pkt_t t;
        t.chip = c; t.pixel = a; t.stamp = s; t.hits = h;
        return t;
    endfunction

    function automatic int sat(input int v, input int w);
        return (v < (1 << w) - 1) ? v + 1 : v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int f = 0; f < 4; f++) begin q[f].delete(); drop0[f] = 0; end
        for (int o = 0; o < 2; o++) begin
            tie[o] = 0; slot_v[o] = 1'b0; slot_d[o] = '0; drop1[o] = 0;
        end
    endtask

    // One cycle: drive at negedge, check outputs, advance the model to the next edge
    task automatic step(input logic iv0, input logic [PW-1:0] ip0,
                        input logic iv1, input logic [PW-1:0] ip1,
                        input logic ir0, input logic ir1);
        logic rr [2];
        logic popf [4];
        logic take [2];
        int sz [4];
        @(negedge clk);
        v0 = iv0; p0 = ip0; v1 = iv1; p1 = ip1; r0 = ir0; r1 = ir1;
        rr[0] = ir0; rr[1] = ir1;
        #1;
        for (int f = 0; f < 4; f++) begin popf[f] = 1'b0; sz[f] = q[f].size(); end
        for (int o = 0; o < 2; o++) begin
            int ca, cb;
            logic ev, ta;
            logic [PW-1:0] ed;
            ca = sz[o]; cb = sz[2+o];
            ev = rr[o] && (ca + cb > 0);
            ta = (ca > cb) || (ca == cb && tie[o] == 0);
            ed = '0;
            if (ev) ed = ta ? q[o][0] : q[2+o][0];
            chk(a_ov[o] == ev, "R5 valid", PW'(a_ov[o]), PW'(ev));
            if (ev) chk(a_op[o] == ed, tag, a_op[o], ed);
            if (ev) begin popf[ta ? o : 2+o] = 1'b1; if (ca == cb) tie[o] = 1 - tie[o]; end
            take[o] = rr[o] && slot_v[o];
            chk(b_ov[o] == take[o], "R9 valid", PW'(b_ov[o]), PW'(take[o]));
            if (take[o]) chk(b_op[o] == slot_d[o], "R9 data", b_op[o], slot_d[o]);
            chk(b_dr[o] == DW1'(drop1[o]), "R9 R7 drop", PW'(b_dr[o]), PW'(drop1[o]));
            chk(b_dr[2+o] == '0, "R10 drop", PW'(b_dr[2+o]), '0);
        end
        for (int f = 0; f < 4; f++)
            chk(a_dr[f] == DW0'(drop0[f]), "R6 R7 drop", PW'(a_dr[f]), PW'(drop0[f]));
        if (!rst_n) return;
        for (int f = 0; f < 4; f++) if (popf[f]) void'(q[f].pop_front());
        if (iv0) begin
            int f; f = rb(ip0, SEL0) ? 1 : 0;
            if (sz[f] < DEPTH) q[f].push_back(ip0); else drop0[f] = sat(drop0[f], DW0);
        end
        if (iv1) begin
            int f; f = rb(ip1, SEL0) ? 3 : 2;
            if (sz[f] < DEPTH) q[f].push_back(ip1); else drop0[f] = sat(drop0[f], DW0);
        end
        for (int o = 0; o < 2; o++) if (take[o]) slot_v[o] = 1'b0;
        if (iv0) begin
            int o; o = rb(ip0, SEL1) ? 1 : 0;
            if (!slot_v[o]) begin slot_v[o] = 1'b1; slot_d[o] = ip0; end
            else drop1[o] = sat(drop1[o], DW1);
        end
    endtask

    task automatic idle(input int n, input logic ir0, input logic ir1);
        for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0, '0, ir0, ir1);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R5 watchdog act=running exp=finished");
        finish_up();
    end

    initial begin
        logic [63:0] rnd;
        model_reset();
        // R8: reset state with ready high
        tag = "R8";
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, '0, 1'b1, 1'b1);
        rst_n = 1'b1;
        idle(2, 1'b1, 1'b1);

        // R1: route bit 0 then 1 (stamp bit 2 for u0, bit 0 for u1)
        tag = "R1";
        step(1'b1, mk(4'h3, 13'h0a5, 9'b0_0000_0000, 8'h5a), 1'b0, '0, 1'b0, 1'b0);
        step(1'b1, mk(4'hc, 13'h1f0, 9'b1_0000_0101, 8'ha5), 1'b0, '0, 1'b0, 1'b0);
        idle(3, 1'b1, 1'b1);

        // R2: burst from input 0 to output 0, drained afterwards
        tag = "R2";
        for (int k = 0; k < 6; k++)
            step(1'b1, mk(4'(k), 13'(k * 7), 9'(k * 8), 8'(k)), 1'b0, '0, 1'b0, 1'b0);
        idle(8, 1'b1, 1'b0);

        // R3: three words vs one word behind output 1
        tag = "R3";
        for (int k = 0; k < 3; k++)
            step(1'b1, mk(4'h1, 13'(k), 9'h004, 8'(k)), (k == 0), mk(4'h2, 13'h99, 9'h0fc, 8'hee), 1'b0, 1'b0);
        idle(6, 1'b0, 1'b1);

        // R4: equal fill on both candidates of output 0
        tag = "R4";
        for (int k = 0; k < 3; k++)
            step(1'b1, mk(4'h5, 13'(k), 9'h000, 8'(k)), 1'b1, mk(4'h6, 13'(k), 9'h1f0, 8'(k)), 1'b0, 1'b0);
        idle(8, 1'b1, 1'b1);

        // R6 R7 R9: overflow with ready held low
        tag = "R6";
        for (int k = 0; k < 26; k++)
            step(1'b1, mk(4'h7, 13'(k), 9'h005, 8'(k)), 1'b1, mk(4'h8, 13'(k), 9'h004, 8'(k)), 1'b0, 1'b0);
        idle(20, 1'b1, 1'b1);

        // R10: traffic on input 1 only
        tag = "R10";
        for (int k = 0; k < 10; k++)
            step(1'b0, '0, 1'b1, mk(4'h9, 13'(k), 9'(k), 8'(k)), 1'b1, 1'(k % 2));
        idle(12, 1'b1, 1'b1);

        // Seeded random mix, model compares every cycle
        tag = "R2 R3 R4 random";
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            logic [PW-1:0] ra, rb2;
            rnd = {$urandom(), $urandom()}; ra = rnd[PW-1:0];
            rnd = {$urandom(), $urandom()}; rb2 = rnd[PW-1:0];
            step(($urandom() % 2) == 0, ra, ($urandom() % 2) == 0, rb2,
                 ($urandom() % 10) < 6, ($urandom() % 10) < 6);
        end
        idle(30, 1'b1, 1'b1);
        finish_up();
    end

endmodule